// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block decides when a small processor core takes an interrupt and then runs the context-save sequence for it. Three level-sensitive request lines can be masked. One further request, a software trap or a hardware breakpoint, ignores the global enable and the per-line masks. The unit holds a global enable flag, a mask bit for each line and a sticky pending-status bit for each line. It also holds the stack pointer and a data-value-match register.

An interrupt can be taken only while the sequencer is idle. When one is taken, the stack pointer drops by one and the current program counter is written to that stack slot through a simple write handshake. The unit then gives a one-cycle load of the service-routine vector to the core. Return commands pop the stack slot and can set the global enable again. While a trap or breakpoint routine is running, no other request is taken until a return arrives. Software can write the enable and the mask bits and can clear the status bits. When a software write and a hardware update hit the same bit in the same cycle, the hardware update wins.

Top module: `irq_accept_unit`

## Requirements
- R1: A maskable line k is taken only in a cycle where the sequencer is idle, `interruptible` is 1, `ret_cmd` is 0, no trap routine is active, `gie` is 1 and `mask[k]` is 1.
- R2: When several lines are eligible at the same clock edge, the lowest index wins (line 0 before line 1 before line 2). Requests held while `gie` is 0 are taken in the same order once `gie` is set again.
- R3: At the accepting edge `sp` drops by one. From the next cycle, `mem_wr_en` is 1 with `mem_addr` equal to the new `sp` and `mem_wdata` equal to the `cur_pc` sampled at acceptance, held until `mem_wr_ack` is 1. In the following cycle `pc_load` is 1 for one cycle with the vector (line k: 0x0010*(k+1); trap: 0x0002), and then the unit is idle.
- R4: Taking a maskable line clears `gie` and leaves `mask` unchanged.
- R5: Taking line k sets `ip[k]`. The bit stays set until software clears it.
- R6: A return command in an idle cycle raises `sp` by one. If `ret_ie` is 1 it also sets `gie`; if `ret_ie` is 0 it leaves `gie` unchanged.
- R7: The trap request beats every maskable line, needs only `interruptible`, loads vector 0x0002, copies `cur_pc` into `dvm` and leaves `gie` and `ip` unchanged.
- R8: While `trap_active` is 1 no request is taken, whatever `gie` and `mask` are. A return command clears `trap_active`.
- R9: A software write (`sw_we`=1) loads `gie` from `sw_gie` and `mask` from `sw_mask`, and clears each `ip` bit whose `sw_ip_clr` bit is 1. An acceptance or a return with enable in the same cycle overrides the write.
- R10: After reset `gie`, `mask`, `ip`, `trap_active`, `dvm`, `busy`, `mem_wr_en` and `pc_load` are 0, and `sp` is 0x0400.
- R11: While `busy` is 1, requests are not taken and return commands have no effect on `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_req | input | 3 | Level-sensitive maskable requests, bit k is line k |
| trap_req | input | 1 | Software trap or breakpoint request |
| interruptible | input | 1 | Core is at a point where it may be interrupted |
| ret_cmd | input | 1 | Return command, one cycle |
| ret_ie | input | 1 | The return also sets the global enable |
| cur_pc | input | 16 | Current program counter of the core |
| sw_we | input | 1 | Software write strobe |
| sw_gie | input | 1 | Global enable value to write |
| sw_mask | input | 3 | Mask value to write |
| sw_ip_clr | input | 3 | Status bits to clear |
| mem_wr_ack | input | 1 | Stack write accepted |
| mem_wr_en | output | 1 | Stack write request |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 16 | Stack write data (saved PC) |
| pc_load | output | 1 | Load vector into PC, one cycle |
| pc_load_val | output | 16 | Vector address |
| busy | output | 1 | Context-save sequence in progress |
| gie | output | 1 | Global interrupt enable |
| mask | output | 3 | Per-line mask bits |
| ip | output | 3 | Per-line pending-status bits |
| trap_active | output | 1 | Trap or breakpoint routine running |
| sp | output | 16 | Stack pointer |
| dvm | output | 16 | Data-value-match register |

## Verification
An accepted request updates `sp`, `gie`, `ip`, `trap_active`, `dvm` and `mem_wr_en` at the edge that samples it, so the bench reads them at the next falling edge. `pc_load` follows one cycle after the edge at which the write is acknowledged. A return or a software write shows on the outputs one edge after its strobe. The bench drives every stimulus on a falling edge and samples exactly one falling edge after the register stage that produces the result. It sweeps every combination of request lines, mask, enable, interruptible and trap, and then runs directed cases for stalls, collisions, nesting and blocking.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int AW     = 16;
    localparam int NLINES = 3;

    typedef logic [AW-1:0]     word_t;
    typedef logic [NLINES-1:0] line_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_VECT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic  valid;
        logic  is_trap;
        line_t line_oh;
        word_t vector;
    } take_t;

    // Lowest set bit wins.
    function automatic line_t lowest_set(input line_t v);
        line_t r;
        logic  found;
        r     = '0;
        found = 1'b0;
        for (int k = 0; k < NLINES; k++) begin
            if (v[k] && !found) begin
                r[k]  = 1'b1;
                found = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
    import irq_pkg::*;
#(
    parameter word_t VEC_BASE = 16'h0010,
    parameter word_t VEC_STEP = 16'h0010,
    parameter word_t TRAP_VEC = 16'h0002
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t req,
    input  line_t mask,
    input  logic  gie,
    input  logic  interruptible,
    input  logic  trap_req,
    input  logic  trap_active,
    input  logic  idle,
    input  logic  ret_cmd,
    output take_t take
);
    logic  open_win;
    line_t eligible;
    line_t grant_oh;
    logic  trap_grant;
    word_t line_vec;

    assign open_win   = idle && interruptible && !ret_cmd && !trap_active;
    assign trap_grant = open_win && trap_req;
    assign eligible   = req & mask & {NLINES{gie}};
    assign grant_oh   = (open_win && !trap_req) ? lowest_set(eligible) : '0;

    always_comb begin
        line_vec = '0;
        for (int k = 0; k < NLINES; k++) begin
            if (grant_oh[k]) line_vec = VEC_BASE + VEC_STEP * word_t'(k);
        end
    end

    always_comb begin
        take.valid   = trap_grant || (|grant_oh);
        take.is_trap = trap_grant;
        take.line_oh = grant_oh;
        take.vector  = trap_grant ? TRAP_VEC : line_vec;
    end

    a_r1_gate: assert property (@(posedge clk) disable iff (rst)
        (|take.line_oh) |-> (gie && interruptible && idle &&
                             ((take.line_oh & ~(req & mask)) == '0)));
    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take.line_oh));
    a_r7_trap_first: assert property (@(posedge clk) disable iff (rst)
        (trap_req && open_win) |-> (take.is_trap && take.line_oh == '0));
    a_r8_blocked: assert property (@(posedge clk) disable iff (rst)
        trap_active |-> !take.valid);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t take_line,
    input  logic  take_trap,
    input  logic  ret_eff,
    input  logic  ret_ie,
    input  logic  sw_we,
    input  logic  sw_gie,
    input  line_t sw_mask,
    input  line_t sw_ip_clr,
    output logic  gie,
    output line_t mask,
    output line_t ip,
    output logic  trap_active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gie         <= 1'b0;
            mask        <= '0;
            ip          <= '0;
            trap_active <= 1'b0;
        end else begin
            if (|take_line)            gie <= 1'b0;
            else if (ret_eff && ret_ie) gie <= 1'b1;
            else if (sw_we)             gie <= sw_gie;

            if (sw_we) mask <= sw_mask;

            ip <= (sw_we ? (ip & ~sw_ip_clr) : ip) | take_line;

            if (take_trap)    trap_active <= 1'b1;
            else if (ret_eff) trap_active <= 1'b0;
        end
    end

    a_r4_gie_clr: assert property (@(posedge clk) disable iff (rst)
        (|take_line) |=> !gie);
    a_r4_mask_kept: assert property (@(posedge clk) disable iff (rst)
        ((|take_line) && !sw_we) |=> (mask == $past(mask)));
    a_r5_ip_set: assert property (@(posedge clk) disable iff (rst)
        (|take_line) |=> ((ip & $past(take_line)) == $past(take_line)));
    a_r8_trap_set: assert property (@(posedge clk) disable iff (rst)
        take_trap |=> trap_active);
    a_r6_ret_enable: assert property (@(posedge clk) disable iff (rst)
        (ret_eff && ret_ie && !(|take_line)) |=> gie);
endmodule

// File: rtl/irq_ctx_seq.sv
module irq_ctx_seq
    import irq_pkg::*;
#(
    parameter word_t SP_RESET = 16'h0400
) (
    input  logic  clk,
    input  logic  rst,
    input  take_t take,
    input  logic  ret_cmd,
    input  word_t cur_pc,
    input  logic  mem_wr_ack,
    output logic  idle,
    output logic  mem_wr_en,
    output word_t mem_addr,
    output word_t mem_wdata,
    output logic  pc_load,
    output word_t pc_load_val,
    output word_t sp,
    output word_t dvm
);
    seq_state_e state;
    word_t      saved_pc;
    word_t      vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            sp       <= SP_RESET;
            saved_pc <= '0;
            vec_q    <= '0;
            dvm      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take.valid) begin
                        sp       <= sp - word_t'(1);
                        saved_pc <= cur_pc;
                        vec_q    <= take.vector;
                        if (take.is_trap) dvm <= cur_pc;
                        state    <= ST_WRITE;
                    end else if (ret_cmd) begin
                        sp <= sp + word_t'(1);
                    end
                end
                ST_WRITE: if (mem_wr_ack) state <= ST_VECT;
                ST_VECT:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign idle        = (state == ST_IDLE);
    assign mem_wr_en   = (state == ST_WRITE);
    assign mem_addr    = sp;
    assign mem_wdata   = saved_pc;
    assign pc_load     = (state == ST_VECT);
    assign pc_load_val = vec_q;

    a_r3_sp_dec: assert property (@(posedge clk) disable iff (rst)
        (idle && take.valid) |=> (sp == $past(sp) - word_t'(1)));
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && !mem_wr_ack) |=> (mem_wr_en && $stable(mem_addr) && $stable(mem_wdata)));
    a_r3_load_after_ack: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && mem_wr_ack) |=> (pc_load && !mem_wr_en));
    a_r11_busy_sp: assert property (@(posedge clk) disable iff (rst)
        (!idle && !(mem_wr_en && mem_wr_ack)) |=> $stable(sp));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter word_t VEC_BASE = 16'h0010,
    parameter word_t VEC_STEP = 16'h0010,
    parameter word_t TRAP_VEC = 16'h0002,
    parameter word_t SP_RESET = 16'h0400
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  int_req,
    input  logic        trap_req,
    input  logic        interruptible,
    input  logic        ret_cmd,
    input  logic        ret_ie,
    input  logic [15:0] cur_pc,
    input  logic        sw_we,
    input  logic        sw_gie,
    input  logic [2:0]  sw_mask,
    input  logic [2:0]  sw_ip_clr,
    input  logic        mem_wr_ack,
    output logic        mem_wr_en,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        pc_load,
    output logic [15:0] pc_load_val,
    output logic        busy,
    output logic        gie,
    output logic [2:0]  mask,
    output logic [2:0]  ip,
    output logic        trap_active,
    output logic [15:0] sp,
    output logic [15:0] dvm
);
    take_t take;
    logic  idle;
    logic  ret_eff;

    assign ret_eff = ret_cmd && idle;
    assign busy    = !idle;

    irq_prio_arb #(
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .TRAP_VEC(TRAP_VEC)
    ) arb_i (
        .clk(clk), .rst(rst), .req(int_req), .mask(mask), .gie(gie),
        .interruptible(interruptible), .trap_req(trap_req),
        .trap_active(trap_active), .idle(idle), .ret_cmd(ret_cmd), .take(take)
    );

    irq_ctrl_regs regs_i (
        .clk(clk), .rst(rst), .take_line(take.line_oh), .take_trap(take.is_trap),
        .ret_eff(ret_eff), .ret_ie(ret_ie), .sw_we(sw_we), .sw_gie(sw_gie),
        .sw_mask(sw_mask), .sw_ip_clr(sw_ip_clr), .gie(gie), .mask(mask),
        .ip(ip), .trap_active(trap_active)
    );

    irq_ctx_seq #(.SP_RESET(SP_RESET)) seq_i (
        .clk(clk), .rst(rst), .take(take), .ret_cmd(ret_cmd), .cur_pc(cur_pc),
        .mem_wr_ack(mem_wr_ack), .idle(idle), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
        .pc_load_val(pc_load_val), .sp(sp), .dvm(dvm)
    );

    a_r11_no_take_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> !take.valid);
endmodule

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  int_req = '0;
    logic        trap_req = 1'b0, interruptible = 1'b0, ret_cmd = 1'b0, ret_ie = 1'b0;
    logic [15:0] cur_pc = '0;
    logic        sw_we = 1'b0, sw_gie = 1'b0;
    logic [2:0]  sw_mask = '0, sw_ip_clr = '0;
    logic        mem_wr_ack = 1'b1;
    logic        mem_wr_en, pc_load, busy, gie, trap_active;
    logic [15:0] mem_addr, mem_wdata, pc_load_val, sp, dvm;
    logic [2:0]  mask, ip;

    int checks = 0;
    int errors = 0;
    logic [15:0] sp_m = 16'h0400;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_accept_unit dut_i (
        .clk(clk), .rst(rst), .int_req(int_req), .trap_req(trap_req),
        .interruptible(interruptible), .ret_cmd(ret_cmd), .ret_ie(ret_ie),
        .cur_pc(cur_pc), .sw_we(sw_we), .sw_gie(sw_gie), .sw_mask(sw_mask),
        .sw_ip_clr(sw_ip_clr), .mem_wr_ack(mem_wr_ack), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
        .pc_load_val(pc_load_val), .busy(busy), .gie(gie), .mask(mask), .ip(ip),
        .trap_active(trap_active), .sp(sp), .dvm(dvm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic g, input logic [2:0] m, input logic [2:0] clr);
        @(negedge clk);
        sw_we = 1'b1; sw_gie = g; sw_mask = m; sw_ip_clr = clr;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    // Called one falling edge after the accepting edge, with ack held high.
    task automatic finish_seq(input logic [15:0] vec);
        @(negedge clk);
        chk("R3 pc_load", 32'(pc_load), 32'd1);
        chk("R3 vector", 32'(pc_load_val), 32'(vec));
        @(negedge clk);
        chk("R3 idle", 32'(busy), 32'd0);
    endtask

    task automatic do_ret(input logic ie);
        @(negedge clk);
        ret_cmd = 1'b1; ret_ie = ie;
        @(negedge clk);
        ret_cmd = 1'b0; ret_ie = 1'b0;
        sp_m = sp_m + 16'd1;
        chk("R6 sp pop", 32'(sp), 32'(sp_m));
        chk("R8 trap cleared", 32'(trap_active), 32'd0);
    endtask

    task automatic run_case(input logic g, input logic i, input logic t,
                            input logic [2:0] req, input logic [2:0] m, input logic [15:0] pcv);
        logic       tw;
        logic [2:0] el;
        int         w;
        sw_write(g, m, 3'b111);
        int_req = req; trap_req = t; interruptible = i; cur_pc = pcv;
        @(negedge clk);
        int_req = '0; trap_req = 1'b0; interruptible = 1'b0;
        tw = t && i;
        el = (i && g) ? (req & m) : 3'b000;
        w = -1;
        for (int k = 2; k >= 0; k--) if (el[k]) w = k;
        if (tw) begin
            sp_m = sp_m - 16'd1;
            chk("R7 trap busy", 32'(busy), 32'd1);
            chk("R3 sp dec", 32'(sp), 32'(sp_m));
            chk("R3 wr addr", 32'(mem_addr), 32'(sp_m));
            chk("R3 wr data", 32'(mem_wdata), 32'(pcv));
            chk("R7 dvm", 32'(dvm), 32'(pcv));
            chk("R7 gie kept", 32'(gie), 32'(g));
            chk("R7 ip kept", 32'(ip), 32'd0);
            chk("R8 trap active", 32'(trap_active), 32'd1);
            finish_seq(16'h0002);
            do_ret(1'b1);
            chk("R6 gie set", 32'(gie), 32'd1);
        end else if (w >= 0) begin
            sp_m = sp_m - 16'd1;
            chk("R1 taken", 32'(busy), 32'd1);
            chk("R3 wr en", 32'(mem_wr_en), 32'd1);
            chk("R3 sp dec", 32'(sp), 32'(sp_m));
            chk("R3 wr data", 32'(mem_wdata), 32'(pcv));
            chk("R2 R5 ip winner", 32'(ip), 32'(1 << w));
            chk("R4 gie cleared", 32'(gie), 32'd0);
            chk("R4 mask kept", 32'(mask), 32'(m));
            finish_seq(16'(16 * (w + 1)));
            do_ret(1'b1);
            chk("R6 gie set", 32'(gie), 32'd1);
        end else begin
            chk("R1 not taken", 32'(busy), 32'd0);
            chk("R1 ip clear", 32'(ip), 32'd0);
            chk("R1 sp kept", 32'(sp), 32'(sp_m));
            chk("R9 gie written", 32'(gie), 32'(g));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        chk("R10 gie", 32'(gie), 32'd0);
        chk("R10 mask", 32'(mask), 32'd0);
        chk("R10 ip", 32'(ip), 32'd0);
        chk("R10 trap", 32'(trap_active), 32'd0);
        chk("R10 sp", 32'(sp), 32'h0400);
        chk("R10 dvm", 32'(dvm), 32'd0);
        chk("R10 busy", 32'(busy | mem_wr_en | pc_load), 32'd0);

        // Exhaustive sweep
        for (int g = 0; g < 2; g++)
            for (int i = 0; i < 2; i++)
                for (int t = 0; t < 2; t++)
                    for (int r = 0; r < 8; r++)
                        for (int m = 0; m < 8; m++)
                            run_case(g[0], i[0], t[0], r[2:0], m[2:0],
                                     16'h1000 + 16'(g*256 + i*128 + t*64 + r*8 + m));

        // R3 R11: stalled write holds, return ignored while busy
        sw_write(1'b1, 3'b111, 3'b111);
        mem_wr_ack = 1'b0;
        int_req = 3'b100; interruptible = 1'b1; cur_pc = 16'hBEEF;
        @(negedge clk);
        int_req = '0; interruptible = 1'b0;
        sp_m = sp_m - 16'd1;
        ret_cmd = 1'b1; ret_ie = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R3 stall wr en", 32'(mem_wr_en), 32'd1);
            chk("R3 stall no load", 32'(pc_load), 32'd0);
            chk("R11 sp kept while busy", 32'(sp), 32'(sp_m));
        end
        ret_cmd = 1'b0; ret_ie = 1'b0;
        chk("R11 gie untouched while busy", 32'(gie), 32'd0);
        mem_wr_ack = 1'b1;
        finish_seq(16'h0030);
        do_ret(1'b0);
        chk("R6 plain return leaves gie", 32'(gie), 32'd0);

        // R9: hardware wins over a same-cycle software write
        sw_write(1'b1, 3'b111, 3'b111);
        @(negedge clk);
        int_req = 3'b010; interruptible = 1'b1;
        sw_we = 1'b1; sw_gie = 1'b1; sw_mask = 3'b111; sw_ip_clr = 3'b111;
        @(negedge clk);
        sw_we = 1'b0; int_req = '0; interruptible = 1'b0;
        sp_m = sp_m - 16'd1;
        chk("R9 gie hw wins", 32'(gie), 32'd0);
        chk("R9 ip hw wins", 32'(ip), 32'b010);
        finish_seq(16'h0020);
        // R9: return-with-enable beats a write of 0
        @(negedge clk);
        ret_cmd = 1'b1; ret_ie = 1'b1;
        sw_we = 1'b1; sw_gie = 1'b0; sw_mask = 3'b111; sw_ip_clr = 3'b000;
        @(negedge clk);
        ret_cmd = 1'b0; ret_ie = 1'b0; sw_we = 1'b0;
        sp_m = sp_m + 16'd1;
        chk("R9 ret enable wins", 32'(gie), 32'd1);
        chk("R5 ip sticky", 32'(ip), 32'b010);
        sw_write(1'b0, 3'b111, 3'b010);
        chk("R9 ip cleared", 32'(ip), 32'd0);

        // R2: requests held while disabled, taken in order on enable
        int_req = 3'b110; interruptible = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 held while disabled", 32'(busy), 32'd0);
        sw_we = 1'b1; sw_gie = 1'b1; sw_mask = 3'b111; sw_ip_clr = 3'b000;
        @(negedge clk);
        sw_we = 1'b0;
        chk("R2 enable takes effect", 32'(gie), 32'd1);
        @(negedge clk);
        int_req = '0; interruptible = 1'b0;
        sp_m = sp_m - 16'd1;
        chk("R2 line1 first", 32'(ip), 32'b010);
        finish_seq(16'h0020);
        // Nesting: routine re-enables, line 0 taken on top
        sw_write(1'b1, 3'b111, 3'b000);
        int_req = 3'b101; interruptible = 1'b1; cur_pc = 16'h0021;
        @(negedge clk);
        int_req = '0; interruptible = 1'b0;
        sp_m = sp_m - 16'd1;
        chk("R2 nested line0", 32'(ip), 32'b011);
        chk("R3 nested sp", 32'(sp), 32'(sp_m));
        finish_seq(16'h0010);
        do_ret(1'b1);
        do_ret(1'b1);

        // R8: trap routine blocks maskable lines
        sw_write(1'b1, 3'b111, 3'b111);
        trap_req = 1'b1; int_req = 3'b001; interruptible = 1'b1; cur_pc = 16'h4242;
        @(negedge clk);
        trap_req = 1'b0;
        sp_m = sp_m - 16'd1;
        chk("R7 trap over line0", 32'(ip), 32'd0);
        @(negedge clk);
        @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R8 line blocked", 32'(busy), 32'd0);
        chk("R8 ip blocked", 32'(ip), 32'd0);
        chk("R8 sp unchanged", 32'(sp), 32'(sp_m));
        int_req = '0; interruptible = 1'b0;
        do_ret(1'b0);
        chk("R8 gie unaffected", 32'(gie), 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule